// File: doc/BRIEF.md
# Switch-Driven Operand Capture Controller

This block is the front end between a bank of switches, one push button and a 16-bit ALU. Two mode switches choose what the button does. In either capture mode, each press adds the data switches into the chosen operand register. The register is not overwritten, so N presses leave N times the switch value in it. A result mode shows the ALU output on the LEDs, and a self-test mode hands the LEDs to an external test sequencer.

The raw button passes through a two-stage synchronizer and a rising-edge detector. Each press therefore counts once, however long the button is held. When the user switches into a capture mode from any other mode, that operand starts again from zero. Both operand registers drive the ALU inputs at all times. The function code goes to the ALU only in result mode.

Every pin is plain level control or data. The switches are quasi-static, so the block has no handshake and applies no back-pressure.

Top module: `operand_entry_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears both operand registers, so `alu_a` and `alu_b` read 0 after reset.
- R2: With `mode_sw` = 2'b01, each accepted press makes `alu_a` equal to its old value plus `data_sw`, and `alu_b` does not change.
- R3: With `mode_sw` = 2'b10, each accepted press makes `alu_b` equal to its old value plus `data_sw`, and `alu_a` does not change.
- R4: A press is accepted once per low-to-high transition of `btn_in`, however long the button is held. The operand changes at the third rising clock edge after `btn_in` goes high.
- R5: Accumulation wraps modulo 2^16. For example, 0xFFFF added twice to zero gives 0xFFFE.
- R6: On the first cycle in a capture mode after any other mode, the selected operand is cleared to 0. If a press is accepted in that same cycle, the operand becomes exactly `data_sw`.
- R7: In modes 2'b11 and 2'b00, presses leave both operands unchanged.
- R8: `led` shows `alu_y` in mode 2'b11 and `test_led` in mode 2'b00. It shows `alu_a` in mode 2'b01 and `alu_b` in mode 2'b10.
- R9: `alu_fn` equals `func_sw` in mode 2'b11 and is 0 in every other mode.
- R10: `test_run` is high exactly when `mode_sw` = 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sw | input | 2 | Mode select: 01 capture A, 10 capture B, 11 show result, 00 self-test |
| data_sw | input | 16 | Switch value added into the selected operand |
| func_sw | input | 6 | Function code switches |
| btn_in | input | 1 | Raw, asynchronous push button |
| alu_y | input | 16 | Result from the ALU |
| test_led | input | 16 | LED pattern from the test sequencer |
| alu_a | output | 16 | Operand A to the ALU |
| alu_b | output | 16 | Operand B to the ALU |
| alu_fn | output | 6 | Function code to the ALU |
| led | output | 16 | LED drive |
| test_run | output | 1 | High while self-test mode is selected |

## Verification
Two events can fall in the same clock cycle: the clear on entering a capture mode, and an accepted button edge. To provoke this, the bench raises the button while in result mode. It then moves the mode switches to a capture mode exactly in the cycle where the synchronized edge emerges. The only correct result is the bare switch value, not the old operand plus the switch value and not zero. A behavioural model in the bench tracks the synchronizer delay and is compared on every clock, which catches a clear or add that lands one cycle early or late.

// File: rtl/opent_pkg.sv
package opent_pkg;
  typedef enum logic [1:0] {
    MODE_TEST = 2'b00,
    MODE_CAPA = 2'b01,
    MODE_CAPB = 2'b10,
    MODE_SHOW = 2'b11
  } mode_t;
endpackage

// File: rtl/opent_btn_edge.sv
module opent_btn_edge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_in,
  output logic press
);
  localparam int DEPTH = SYNC + 1;

  logic [DEPTH-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[DEPTH-2:0], btn_in};
  end

  // new level at the last sync stage, old level one stage behind
  assign press = sh[SYNC-1] & ~sh[SYNC];
endmodule

// File: rtl/opent_acc.sv
module opent_acc #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active,
  input  logic         enter,
  input  logic         add,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] base;

  always_comb base = enter ? '0 : q;

  always_ff @(posedge clk) begin
    if (rst)                q <= '0;
    else if (active && add) q <= base + din;
    else if (active)        q <= base;
  end
endmodule

// File: rtl/opent_view.sv
module opent_view
  import opent_pkg::*;
#(
  parameter int W = 16,
  parameter int F = 6
) (
  input  mode_t        mode,
  input  logic [W-1:0] alu_y,
  input  logic [W-1:0] test_led,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [F-1:0] func_sw,
  output logic [W-1:0] led,
  output logic [F-1:0] alu_fn
);
  always_comb begin
    unique case (mode)
      MODE_SHOW: led = alu_y;
      MODE_TEST: led = test_led;
      MODE_CAPA: led = opa;
      default:   led = opb;
    endcase
    alu_fn = (mode == MODE_SHOW) ? func_sw : '0;
  end
endmodule

// File: rtl/operand_entry_ctrl.sv
module operand_entry_ctrl
  import opent_pkg::*;
#(
  parameter int W    = 16,
  parameter int F    = 6,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode_sw,
  input  logic [W-1:0] data_sw,
  input  logic [F-1:0] func_sw,
  input  logic         btn_in,
  input  logic [W-1:0] alu_y,
  input  logic [W-1:0] test_led,
  output logic [W-1:0] alu_a,
  output logic [W-1:0] alu_b,
  output logic [F-1:0] alu_fn,
  output logic [W-1:0] led,
  output logic         test_run
);
  localparam int NOPS = 2;

  mode_t      mode;
  logic [1:0] mode_q;
  logic       press;
  logic [W-1:0] opr [NOPS];

  assign mode = mode_t'(mode_sw);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_TEST;
    else     mode_q <= mode_sw;
  end

  opent_btn_edge #(.SYNC(SYNC)) u_btn (
    .clk(clk), .rst(rst), .btn_in(btn_in), .press(press)
  );

  for (genvar gi = 0; gi < NOPS; gi++) begin : g_op
    localparam logic [1:0] MY = 2'(gi + 1);
    logic act;
    assign act = (mode_sw == MY);
    opent_acc #(.W(W)) u_acc (
      .clk(clk), .rst(rst), .active(act), .enter(act && (mode_q != MY)),
      .add(press), .din(data_sw), .q(opr[gi])
    );
  end

  assign alu_a    = opr[0];
  assign alu_b    = opr[1];
  assign test_run = (mode == MODE_TEST);

  opent_view #(.W(W), .F(F)) u_view (
    .mode(mode), .alu_y(alu_y), .test_led(test_led), .opa(opr[0]), .opb(opr[1]),
    .func_sw(func_sw), .led(led), .alu_fn(alu_fn)
  );
endmodule

// File: rtl/operand_entry_chk.sv
module operand_entry_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   mode_sw,
  input logic [1:0]   mode_q,
  input logic         press,
  input logic [W-1:0] data_sw,
  input logic [W-1:0] alu_a,
  input logic [W-1:0] alu_b
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (alu_a == '0 && alu_b == '0));

  assert_add_a_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_sw == 2'b01 && mode_q == 2'b01 && press) |=>
      (alu_a == W'($past(alu_a) + $past(data_sw))));

  assert_add_b_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_sw == 2'b10 && mode_q == 2'b10 && press) |=>
      (alu_b == W'($past(alu_b) + $past(data_sw))));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    press |=> !press);

  assert_entry_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_sw == 2'b01 && mode_q != 2'b01 && !press) |=> (alu_a == '0));

  assert_hold_a_R7: assert property (@(posedge clk) disable iff (rst)
    (!rst && mode_sw != 2'b01) |=> $stable(alu_a));

  assert_hold_b_R7: assert property (@(posedge clk) disable iff (rst)
    (!rst && mode_sw != 2'b10) |=> $stable(alu_b));
endmodule

bind operand_entry_ctrl operand_entry_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .mode_sw(mode_sw), .mode_q(mode_q), .press(press),
  .data_sw(data_sw), .alu_a(alu_a), .alu_b(alu_b)
);

// File: tb/operand_entry_ctrl_tb.sv
`timescale 1ns/100ps
module operand_entry_ctrl_tb;
  logic clk = 0;
  logic rst = 1;
  logic [1:0]  mode_sw = 2'b00;
  logic [15:0] data_sw = 0, alu_y = 16'hA5A5, test_led = 16'h0F0F;
  logic [5:0]  func_sw = 6'h15;
  logic btn_in = 0;
  logic [15:0] alu_a, alu_b, led;
  logic [5:0]  alu_fn;
  logic test_run;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  operand_entry_ctrl u_dut (
    .clk(clk), .rst(rst), .mode_sw(mode_sw), .data_sw(data_sw), .func_sw(func_sw),
    .btn_in(btn_in), .alu_y(alu_y), .test_led(test_led), .alu_a(alu_a), .alu_b(alu_b),
    .alu_fn(alu_fn), .led(led), .test_run(test_run)
  );

  // behavioural reference: button history and operand values
  bit   h1, h2, h3;
  int   m_prev_mode;
  int   m_a, m_b;
  bit   model_on = 0;

  always @(posedge clk) begin
    bit edge_seen;
    if (rst) begin
      h1 = 0; h2 = 0; h3 = 0; m_a = 0; m_b = 0; m_prev_mode = 0;
    end else begin
      edge_seen = h2 && !h3;
      if (mode_sw == 2'b01) begin
        if (m_prev_mode != 1) m_a = 0;
        if (edge_seen) m_a = (m_a + data_sw) % 65536;
      end
      if (mode_sw == 2'b10) begin
        if (m_prev_mode != 2) m_b = 0;
        if (edge_seen) m_b = (m_b + data_sw) % 65536;
      end
      h3 = h2; h2 = h1; h1 = btn_in;
      m_prev_mode = mode_sw;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && !rst) begin
      int e_led;
      chk("R2 model alu_a", alu_a, m_a);
      chk("R3 model alu_b", alu_b, m_b);
      case (mode_sw)
        2'b11: e_led = alu_y;
        2'b00: e_led = test_led;
        2'b01: e_led = m_a;
        default: e_led = m_b;
      endcase
      chk("R8 model led", led, e_led);
      chk("R9 model alu_fn", alu_fn, (mode_sw == 2'b11) ? func_sw : 0);
      chk("R10 model test_run", test_run, mode_sw == 2'b00);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic press(int hold);
    btn_in = 1; step(hold);
    btn_in = 0; step(4);
  endtask

  initial begin
    step(3);
    rst = 0; model_on = 1;
    step(1);
    chk("R1 reset a", alu_a, 0);
    chk("R1 reset b", alu_b, 0);
    chk("R10 test_run", test_run, 1);

    // R2: three presses of 0x1234
    mode_sw = 2'b01; data_sw = 16'h1234; step(2);
    // R4: latency, button raised just after edge k; change at edge k+3
    btn_in = 1; step(2);
    chk("R4 no change yet", alu_a, 0);
    step(1);
    chk("R4 added at third edge", alu_a, 16'h1234);
    step(10); // long hold: no extra add
    chk("R4 long hold single add", alu_a, 16'h1234);
    btn_in = 0; step(4);
    press(3); press(5);
    chk("R2 three presses", alu_a, 16'h369C);
    chk("R2 b untouched", alu_b, 0);

    // R3 and R5: wrap
    mode_sw = 2'b10; data_sw = 16'hFFFF; step(2);
    press(3); press(3);
    chk("R5 wrap", alu_b, 16'hFFFE);
    chk("R3 a untouched", alu_a, 16'h369C);

    // R7: presses ignored in show and test modes
    mode_sw = 2'b11; data_sw = 16'h0101; step(2);
    chk("R9 func in show", alu_fn, 6'h15);
    chk("R8 led in show", led, 16'hA5A5);
    press(3);
    chk("R7 show a", alu_a, 16'h369C);
    chk("R7 show b", alu_b, 16'hFFFE);
    mode_sw = 2'b00; step(2);
    press(3);
    chk("R7 test a", alu_a, 16'h369C);
    chk("R8 led in test", led, 16'h0F0F);

    // R6: re-entry clears
    mode_sw = 2'b10; step(1);
    chk("R6 entry clear b", alu_b, 0);

    // R6: entry and accepted edge in the same cycle
    mode_sw = 2'b11; data_sw = 16'h0042; step(2);
    btn_in = 1; step(2);
    mode_sw = 2'b01; step(1);
    chk("R6 collision", alu_a, 16'h0042);
    btn_in = 0; step(4);
    chk("R8 led shows a", led, 16'h0042);

    step(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule